// File: doc/BRIEF.md
# Palette Lookup Pixel Pipeline

This block turns a 16-bit pixel word into three 8-bit color codes, one set per pixel clock, ready for a triple video DAC. Each pixel is handled in one of four ways. In palette mode the low byte of the word is ANDed with a mask register and then used to index a 256-entry table of 18-bit colors. The other three modes bypass the table and unpack the word directly as 5-5-5, 5-6-5 or 24-bit color.

A per-pixel select input picks between a primary and a secondary mode, and both are held in configuration registers. An active-low blank input forces black. Every pixel passes through three register stages: capture, table read and output. The mode travels down the pipe with its pixel, so a mode change never disturbs pixels already in flight.

A single host write port, clocked by the pixel clock, loads table entries, the mask and the two mode codes. That port stays usable while the screen is blanked.

Top module: `pix_lut_pipe`

## Requirements
- R1: After reset the color outputs are zero, the mask is all ones, and both the primary and the secondary mode are palette mode.
- R2: Outside 24-bit mode, a pixel driven before rising edge k appears on the outputs after edge k+2, and the outputs hold the previous pixel after edge k+1.
- R3: Palette mode (mode code 0) indexes the table with the masked low byte of the pixel, and the upper byte is ignored. A table word is red in [17:12], green in [11:6] and blue in [5:0]. Each 6-bit value c is widened to {c, c[5:4]}.
- R4: The table index is the pixel's low byte ANDed with the 8-bit mask register.
- R5: Mode code 1 (5-5-5) takes red from [14:10], green from [9:5] and blue from [4:0], and ignores bit 15. Each 5-bit value c is widened to {c, c[4:2]}.
- R6: Mode code 2 (5-6-5) takes red from [15:11], green from [10:5] and blue from [4:0], each widened by repeating its top bits.
- R7: Mode code 3 (24-bit) uses two consecutive visible words. The first word carries green in [15:8] and blue in [7:0], and the second carries red in [7:0]. The output changes only when the second word arrives and holds while the first word passes. Word pairing restarts after any blanked pixel or any pixel in another mode.
- R8: A low mode-select input applies the primary mode to that pixel and a high one applies the secondary mode, decided separately for every pixel.
- R9: A pixel captured with blank low yields zero on all three outputs.
- R10: Host writes take effect for pixels captured after the write edge and are accepted while blanking. The target select is 0 for a table entry (address, data[17:0]), 1 for the mask (data[7:0]) and 2 for the modes (primary in data[1:0], secondary in data[3:2]). Value 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, also used by the host port |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_i | input | 16 | Pixel word |
| blank_n_i | input | 1 | Active-low blank |
| msw_i | input | 1 | Per-pixel select, low primary, high secondary |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Host write target |
| wr_addr_i | input | 8 | Table entry index |
| wr_data_i | input | 18 | Host write data |
| red_o | output | 8 | Red code |
| green_o | output | 8 | Green code |
| blue_o | output | 8 | Blue code |

## Verification
The bench builds the block with its package defaults: a 16-bit pixel word, 6-bit table components, 8-bit outputs and an 8-bit table index. With these values all four mode codes can be reached in one run. A narrowed mask visibly aliases two pixel bytes onto one table entry. The widening rules for both 5-bit and 6-bit fields produce distinct, hand-checkable codes. Pixel streams that mix modes, blanked pixels and 24-bit word pairs show the three-clock latency and the hold behaviour directly at the output pins.

// File: rtl/pix_lut_pkg.sv
package pix_lut_pkg;

    localparam int PIX_W  = 16;
    localparam int COMP_W = 6;
    localparam int OUT_W  = 8;
    localparam int PAL_AW = 8;
    localparam int WORD_W = 3 * COMP_W;
    localparam int F5_W   = 5;
    localparam int F6_W   = 6;

    typedef enum logic [1:0] {
        MODE_PAL = 2'd0,
        MODE_555 = 2'd1,
        MODE_565 = 2'd2,
        MODE_888 = 2'd3
    } pix_mode_e;

    typedef enum logic [1:0] {
        TGT_PAL  = 2'd0,
        TGT_MASK = 2'd1,
        TGT_MODE = 2'd2,
        TGT_NONE = 2'd3
    } wr_tgt_e;

    typedef struct packed {
        logic [OUT_W-1:0] r;
        logic [OUT_W-1:0] g;
        logic [OUT_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             vis;
        pix_mode_e        mode;
        logic             ph;
    } stg1_t;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] held;
        logic             vis;
        pix_mode_e        mode;
        logic             ph;
    } stg2_t;

    typedef struct packed {
        stg1_t s1;
        stg2_t s2;
        rgb_t  o;
    } pipe_t;

    typedef struct packed {
        logic [PAL_AW-1:0] mask;
        pix_mode_e         pri;
        pix_mode_e         sec;
    } cfg_t;

    // Left-justify a w-bit value into OUT_W bits, refilling low bits from its top.
    function automatic logic [OUT_W-1:0] widen(input logic [OUT_W-1:0] v, input int w);
        logic [OUT_W-1:0] o;
        o = '0;
        for (int i = 0; i < OUT_W; i++) begin
            o[OUT_W-1-i] = v[w-1-(i % w)];
        end
        return o;
    endfunction

endpackage

// File: rtl/pix_cfg_regs.sv
module pix_cfg_regs
    import pix_lut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  wr_tgt_e           wr_sel_i,
    input  logic [PAL_AW-1:0] wr_lo_i,
    output cfg_t              cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            unique case (wr_sel_i)
                TGT_MASK: cfg_d.mask = wr_lo_i;
                TGT_MODE: begin
                    cfg_d.pri = pix_mode_e'(wr_lo_i[1:0]);
                    cfg_d.sec = pix_mode_e'(wr_lo_i[3:2]);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask <= '1;
            cfg_q.pri  <= MODE_PAL;
            cfg_q.sec  <= MODE_PAL;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/pix_palette_ram.sv
module pix_palette_ram #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [DW-1:0] wd_i,
    input  logic [AW-1:0] ra_i,
    output logic [DW-1:0] rd_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_q;

    // Read returns the word stored before a same-edge write.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[wa_i] <= wd_i;
        end
        rd_q <= mem_q[ra_i];
    end

    assign rd_o = rd_q;

endmodule

// File: rtl/pix_color_expand.sv
module pix_color_expand
    import pix_lut_pkg::*;
(
    input  pix_mode_e         mode_i,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [PIX_W-1:0]  held_i,
    input  logic [WORD_W-1:0] pal_i,
    output rgb_t              rgb_o
);

    always_comb begin
        rgb_o = '0;
        unique case (mode_i)
            MODE_PAL: begin
                rgb_o.r = widen(OUT_W'(pal_i[3*COMP_W-1 -: COMP_W]), COMP_W);
                rgb_o.g = widen(OUT_W'(pal_i[2*COMP_W-1 -: COMP_W]), COMP_W);
                rgb_o.b = widen(OUT_W'(pal_i[COMP_W-1:0]), COMP_W);
            end
            MODE_555: begin
                rgb_o.r = widen(OUT_W'(pix_i[3*F5_W-1 -: F5_W]), F5_W);
                rgb_o.g = widen(OUT_W'(pix_i[2*F5_W-1 -: F5_W]), F5_W);
                rgb_o.b = widen(OUT_W'(pix_i[F5_W-1:0]), F5_W);
            end
            MODE_565: begin
                rgb_o.r = widen(OUT_W'(pix_i[PIX_W-1 -: F5_W]), F5_W);
                rgb_o.g = widen(OUT_W'(pix_i[F5_W +: F6_W]), F6_W);
                rgb_o.b = widen(OUT_W'(pix_i[F5_W-1:0]), F5_W);
            end
            default: begin
                rgb_o.r = pix_i[OUT_W-1:0];
                rgb_o.g = held_i[2*OUT_W-1 -: OUT_W];
                rgb_o.b = held_i[OUT_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/pix_lut_pipe.sv
module pix_lut_pipe
    import pix_lut_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIX_W-1:0]   pix_i,
    input  logic               blank_n_i,
    input  logic               msw_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [PAL_AW-1:0]  wr_addr_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    output logic [OUT_W-1:0]   red_o,
    output logic [OUT_W-1:0]   green_o,
    output logic [OUT_W-1:0]   blue_o
);

    cfg_t              cfg_q;
    pipe_t             pipe_d, pipe_q;
    logic [PAL_AW-1:0] rd_addr;
    logic [WORD_W-1:0] pal_word;
    rgb_t              exp_rgb;
    wr_tgt_e           wr_tgt;
    pix_mode_e         sel_mode;
    logic              run24;

    assign wr_tgt = wr_tgt_e'(wr_sel_i);

    pix_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_tgt),
        .wr_lo_i  (wr_data_i[PAL_AW-1:0]),
        .cfg_o    (cfg_q)
    );

    pix_palette_ram #(
        .AW (PAL_AW),
        .DW (WORD_W)
    ) u_ram (
        .clk  (clk),
        .we_i (wr_en_i && (wr_tgt == TGT_PAL)),
        .wa_i (wr_addr_i),
        .wd_i (wr_data_i),
        .ra_i (rd_addr),
        .rd_o (pal_word)
    );

    pix_color_expand u_exp (
        .mode_i (pipe_q.s2.mode),
        .pix_i  (pipe_q.s2.pix),
        .held_i (pipe_q.s2.held),
        .pal_i  (pal_word),
        .rgb_o  (exp_rgb)
    );

    assign sel_mode = msw_i ? cfg_q.sec : cfg_q.pri;
    assign run24    = pipe_q.s1.vis && (pipe_q.s1.mode == MODE_888);
    assign rd_addr  = pipe_q.s1.pix[PAL_AW-1:0] & cfg_q.mask;

    always_comb begin
        pipe_d = pipe_q;

        // Stage 1: capture pixel, blank and the mode chosen for this pixel.
        pipe_d.s1.pix  = pix_i;
        pipe_d.s1.vis  = blank_n_i;
        pipe_d.s1.mode = sel_mode;
        pipe_d.s1.ph   = (blank_n_i && (sel_mode == MODE_888)) ? (run24 && !pipe_q.s1.ph) : 1'b0;

        // Stage 2: table read runs in the RAM; pixel fields follow alongside.
        pipe_d.s2.pix  = pipe_q.s1.pix;
        pipe_d.s2.vis  = pipe_q.s1.vis;
        pipe_d.s2.mode = pipe_q.s1.mode;
        pipe_d.s2.ph   = pipe_q.s1.ph;
        if (run24 && !pipe_q.s1.ph) begin
            pipe_d.s2.held = pipe_q.s1.pix;
        end

        // Stage 3: output latch.
        if (!pipe_q.s2.vis) begin
            pipe_d.o = '0;
        end else if ((pipe_q.s2.mode == MODE_888) && !pipe_q.s2.ph) begin
            pipe_d.o = pipe_q.o;
        end else begin
            pipe_d.o = exp_rgb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign red_o   = pipe_q.o.r;
    assign green_o = pipe_q.o.g;
    assign blue_o  = pipe_q.o.b;

endmodule

// File: rtl/pix_lut_pipe_chk.sv
module pix_lut_pipe_chk
    import pix_lut_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PIX_W-1:0]  pix_i,
    input logic              blank_n_i,
    input logic              msw_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_sel_i,
    input logic [OUT_W-1:0]  red_o,
    input logic [OUT_W-1:0]  green_o,
    input logic [OUT_W-1:0]  blue_o,
    input stg1_t             s1,
    input stg2_t             s2,
    input cfg_t              cfg,
    input logic [PAL_AW-1:0] rd_addr
);

    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && !$past(blank_n_i, 3)) |-> ({red_o, green_o, blue_o} == '0)); // R9

    AST_MASK_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0) |-> (rd_addr == ($past(pix_i[PAL_AW-1:0]) & cfg.mask))); // R4

    AST_MASK_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && !$past(wr_en_i && wr_sel_i == 2'd1)) |-> $stable(cfg.mask)); // R10

    AST_MODE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0) |-> (s1.mode == ($past(msw_i) ? $past(cfg.sec) : $past(cfg.pri)))); // R8

    AST_HOLD_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (s2.vis && s2.mode == MODE_888 && !s2.ph) |=> $stable({red_o, green_o, blue_o})); // R7

endmodule

bind pix_lut_pipe pix_lut_pipe_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_i     (pix_i),
    .blank_n_i (blank_n_i),
    .msw_i     (msw_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .red_o     (red_o),
    .green_o   (green_o),
    .blue_o    (blue_o),
    .s1        (pipe_q.s1),
    .s2        (pipe_q.s2),
    .cfg       (cfg_q),
    .rd_addr   (rd_addr)
);

// File: tb/sim_pix_lut_pipe.sv
`timescale 1ns/1ps
module sim_pix_lut_pipe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pix = '0;
    logic        blank_n = 1'b0;
    logic        msw = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [7:0]  wr_addr = '0;
    logic [17:0] wr_data = '0;
    logic [7:0]  red, green, blue;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pix_lut_pipe u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_i     (pix),
        .blank_n_i (blank_n),
        .msw_i     (msw),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .red_o     (red),
        .green_o   (green),
        .blue_o    (blue)
    );

    // {blank_n, msw, pixel[15:0], expected rgb[23:0]}; primary=palette, secondary=5-6-5
    localparam int NV = 10;
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h0012, 24'hFF0055},   // R3
        {1'b1, 1'b0, 16'h00A5, 24'h8204AA},   // R3
        {1'b1, 1'b1, 16'hF800, 24'hFF0000},   // R6 R8
        {1'b1, 1'b0, 16'hFF12, 24'hFF0055},   // R3 upper byte ignored
        {1'b1, 1'b1, 16'h07E0, 24'h00FF00},   // R6
        {1'b0, 1'b0, 16'h00A5, 24'h000000},   // R9
        {1'b1, 1'b1, 16'h8410, 24'h848284},   // R6
        {1'b0, 1'b1, 16'hFFFF, 24'h000000},   // R9
        {1'b1, 1'b0, 16'h0002, 24'h3CC31C},   // R3
        {1'b1, 1'b1, 16'h001F, 24'h0000FF}    // R6
    };

    task automatic check(input string req, input logic [23:0] exp);
        checks++;
        if ({red, green, blue} !== exp) begin
            failures++;
            $display("FAIL %s actual=%06h expected=%06h", req, {red, green, blue}, exp);
        end
    endtask

    task automatic put(input logic b, input logic m, input logic [15:0] p);
        @(negedge clk);
        blank_n = b;
        msw = m;
        pix = p;
    endtask

    task automatic hw(input logic [1:0] sel, input logic [7:0] a, input logic [17:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_sel = 2'd3;
    endtask

    task automatic see(input logic b, input logic m, input logic [15:0] p,
                       input string req, input logic [23:0] exp);
        put(b, m, p);
        repeat (3) @(negedge clk);
        check(req, exp);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 24'h000000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 24'h000000);

        hw(2'd0, 8'h12, {6'h3F, 6'h00, 6'h15});
        hw(2'd0, 8'hA5, {6'h20, 6'h01, 6'h2A});
        hw(2'd0, 8'h02, {6'h0F, 6'h30, 6'h07});
        // Default secondary mode is palette and default mask is all ones.
        see(1'b1, 1'b1, 16'h0012, "R1 default modes and mask", 24'hFF0055);
        put(1'b0, 1'b0, 16'h0000);

        hw(2'd2, 8'h00, 18'h00008);   // primary palette, secondary 5-6-5
        for (int i = 0; i < NV + 3; i++) begin
            @(negedge clk);
            if (i >= 3) check("R3/R6/R8/R9 table", VEC[i-3][23:0]);
            if (i < NV) begin
                blank_n = VEC[i][41];
                msw = VEC[i][40];
                pix = VEC[i][39:24];
            end else begin
                blank_n = 1'b0;
                msw = 1'b0;
                pix = '0;
            end
        end

        // R2: latency
        repeat (3) put(1'b0, 1'b0, 16'h0000);
        put(1'b1, 1'b0, 16'h0012);
        put(1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        check("R2 not yet after two edges", 24'h000000);
        @(negedge clk);
        check("R2 visible after third edge", 24'hFF0055);

        // R4: mask aliases bytes onto entry 0x02
        hw(2'd1, 8'h00, 18'h0000F);
        see(1'b1, 1'b0, 16'h00F2, "R4 mask 0x0F on 0xF2", 24'h3CC31C);
        see(1'b1, 1'b0, 16'h0012, "R4 mask 0x0F on 0x12", 24'h3CC31C);
        put(1'b0, 1'b0, 16'h0000);
        hw(2'd1, 8'h00, 18'h000FF);

        // R5: 5-5-5 primary, palette secondary
        hw(2'd2, 8'h00, 18'h00001);
        see(1'b1, 1'b0, 16'h7C00, "R5 red full", 24'hFF0000);
        see(1'b1, 1'b0, 16'hFC00, "R5 bit15 ignored", 24'hFF0000);
        see(1'b1, 1'b0, 16'h4210, "R5 mid gray", 24'h848484);
        see(1'b1, 1'b1, 16'h0012, "R8 secondary palette", 24'hFF0055);
        put(1'b0, 1'b0, 16'h0000);

        // R7: 24-bit pairs
        hw(2'd2, 8'h00, 18'h00003);
        put(1'b0, 1'b0, 16'h0000);
        put(1'b1, 1'b0, 16'h3456);
        put(1'b1, 1'b0, 16'h0012);
        put(1'b1, 1'b0, 16'hABCD);
        put(1'b1, 1'b0, 16'h00EF);
        @(negedge clk);
        check("R7 first pair", 24'h123456);
        blank_n = 1'b0;
        pix = '0;
        @(negedge clk);
        check("R7 hold on first word", 24'h123456);
        @(negedge clk);
        check("R7 second pair", 24'hEFABCD);

        // R9/R10: write during blank
        hw(2'd2, 8'h00, 18'h00000);
        put(1'b0, 1'b0, 16'h0040);
        hw(2'd0, 8'h40, {6'h01, 6'h02, 6'h03});
        check("R9 black while blanked", 24'h000000);
        see(1'b1, 1'b0, 16'h0040, "R10 entry written in blank", 24'h04080C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule